// File: doc/BRIEF.md
# SIMD High-Half Interleave Unit

This block is a packed-data permute stage. It accepts two source vectors and, within each interleave group, takes the elements from the upper half of both sources. It writes them to the result in alternating order: the first source supplies the lowest element, the second source the next, and so on. The lower half of each group is discarded. The element size can be 8, 16, 32 or 64 bits. The operand width can be 64, 128 or 256 bits.

At 256 bits the block works on two independent 128-bit lanes, and no element moves from one lane to the other. At 128 bits it computes only the low lane. A mode bit then chooses the upper 128 result bits: either the incoming old destination bits are kept, or zeros are written. At 64 bits the whole 64-bit word is one group, and every result bit above bit 63 is zero.

When the second source is all zeros, each upper-half element of the first source comes out zero-extended to twice its width. This lets the block widen data as well as merge it. A transaction is presented with `inValid`. Its result and an error flag for illegal combinations appear one clock later with `outValid`.

Top module: `simd_hi_interleave`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `outValid` and `errOut` are 0.
- R2: `outValid` equals `inValid` of the previous clock. `result` and `errOut` belong to the transaction accepted on that edge, and `errOut` is 0 whenever `outValid` is 0.
- R3: With `widthSel`=2 (256-bit), each 128-bit lane is built separately. Lane output element 2j comes from `srcA` element j of the lane's upper half, and element 2j+1 comes from `srcB` element j of the same half.
- R4: The lower half of every group in both sources has no effect on `result`, and no element crosses a 128-bit lane boundary.
- R5: With `widthSel`=1 (128-bit) and `zeroUpper`=0, `result[255:128]` equals `oldDest[255:128]`, and `result[127:0]` is the single-lane interleave.
- R6: With `widthSel`=1 and `zeroUpper`=1, `result[255:128]` is 0.
- R7: With `widthSel`=0 (64-bit), only source bits 63:32 contribute, interleaved into `result[63:0]`, and `result[255:64]` is 0.
- R8: `widthSel`=3, or `widthSel`=0 together with `elemSel`=3, is illegal. Such a transaction sets `errOut` to 1 and drives `result` to 0.
- R9: When `srcB` is all zeros, `result` holds the upper-half elements of `srcA`, each zero-extended to twice its width.
- R10: `elemSel` codes 0, 1, 2 and 3 select 8-, 16-, 32- and 64-bit elements respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Transaction present on the inputs |
| widthSel | input | 2 | Operand width: 0=64, 1=128, 2=256, 3=illegal |
| elemSel | input | 2 | Element size: 0=8, 1=16, 2=32, 3=64 bits |
| zeroUpper | input | 1 | 128-bit mode: 1 clears result[255:128], 0 keeps oldDest bits |
| srcA | input | 256 | First source vector (supplies even result elements) |
| srcB | input | 256 | Second source vector (supplies odd result elements) |
| oldDest | input | 256 | Prior destination value for the 128-bit merge |
| outValid | output | 1 | Result valid, one cycle after inValid |
| result | output | 256 | Interleaved result |
| errOut | output | 1 | Illegal width/size combination for this result |

## Verification
Some properties are checked on every cycle: the one-cycle valid pipeline, the error flag only appearing with a valid result, a zero result on error, zero upper bits for 64-bit results, and the 128-bit zeroing and merging of the upper destination half. The actual element placement cannot be seen by those checks. That covers which source feeds even and odd slots, ascending order, lane independence, ignoring of the lower halves, and zero-extension with a zero second source. Only the bench's reference model and its directed patterns show these, across all width and size codes.

// File: rtl/hi_ilv_pkg.sv
package hi_ilv_pkg;
  typedef enum logic [1:0] {W64 = 2'd0, W128 = 2'd1, W256 = 2'd2, WBAD = 2'd3} opWidth_e;
  typedef enum logic [1:0] {E8 = 2'd0, E16 = 2'd1, E32 = 2'd2, E64 = 2'd3} elemSize_e;

  localparam int NUM_ELEM_SIZES = 4;
  localparam int MIN_ELEM_W = 8;

  typedef struct packed {
    logic      load;
    logic      err;
    opWidth_e  width;
    elemSize_e elem;
    logic      zeroHi;
  } ilvStrobe_t;
endpackage

// File: rtl/hi_ilv_ctrl.sv
module hi_ilv_ctrl
  import hi_ilv_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic [1:0] widthSel,
  input  logic [1:0] elemSel,
  input  logic       zeroUpper,
  output ilvStrobe_t strb,
  output logic       outValid,
  output logic       errOut
);
  opWidth_e  widthCode;
  elemSize_e elemCode;
  logic      illegal;

  assign widthCode = opWidth_e'(widthSel);
  assign elemCode  = elemSize_e'(elemSel);

  always_comb begin
    illegal = 1'b0;
    if (widthCode == WBAD) illegal = 1'b1;
    if (widthCode == W64 && elemCode == E64) illegal = 1'b1;
  end

  assign strb.load   = inValid & ~rst;
  assign strb.err    = illegal;
  assign strb.width  = widthCode;
  assign strb.elem   = elemCode;
  assign strb.zeroHi = zeroUpper;

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      errOut   <= 1'b0;
    end else begin
      outValid <= inValid;
      errOut   <= inValid & illegal;
    end
  end

  // R2: valid follows the input one clock later
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  a_r2_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);
  // R2: no error without a valid result
  a_r2_err_needs_valid: assert property (@(posedge clk) disable iff (rst)
    errOut |-> outValid);
endmodule

// File: rtl/hi_ilv_datapath.sv
module hi_ilv_datapath
  import hi_ilv_pkg::*;
#(
  parameter int DW       = 256,
  parameter int LANE_W   = 128,
  parameter int NARROW_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  ilvStrobe_t       strb,
  input  logic [DW-1:0]    srcA,
  input  logic [DW-1:0]    srcB,
  input  logic [DW-1:0]    oldDest,
  output logic [DW-1:0]    resultQ
);
  localparam int NLANES = DW / LANE_W;
  localparam int HALF   = LANE_W / 2;
  localparam int NHALF  = NARROW_W / 2;

  logic [DW-1:0]       wideAll   [NUM_ELEM_SIZES];
  logic [NARROW_W-1:0] narrowAll [NUM_ELEM_SIZES];

  for (genvar k = 0; k < NUM_ELEM_SIZES; k++) begin : gSize
    localparam int EW = MIN_ELEM_W << k;
    logic [DW-1:0] wideRes;

    always_comb begin
      wideRes = '0;
      for (int l = 0; l < NLANES; l++) begin
        for (int j = 0; j < HALF / EW; j++) begin
          wideRes[l*LANE_W + (2*j)*EW +: EW]   = srcA[l*LANE_W + HALF + j*EW +: EW];
          wideRes[l*LANE_W + (2*j+1)*EW +: EW] = srcB[l*LANE_W + HALF + j*EW +: EW];
        end
      end
    end
    assign wideAll[k] = wideRes;

    if (EW < NARROW_W) begin : gNarrow
      logic [NARROW_W-1:0] narrowRes;
      always_comb begin
        narrowRes = '0;
        for (int j = 0; j < NHALF / EW; j++) begin
          narrowRes[(2*j)*EW +: EW]   = srcA[NHALF + j*EW +: EW];
          narrowRes[(2*j+1)*EW +: EW] = srcB[NHALF + j*EW +: EW];
        end
      end
      assign narrowAll[k] = narrowRes;
    end else begin : gNoNarrow
      assign narrowAll[k] = '0;
    end
  end

  logic [DW-LANE_W-1:0] upperKeep;
  logic [DW-1:0]        nextRes;

  assign upperKeep = strb.zeroHi ? '0 : oldDest[DW-1:LANE_W];

  always_comb begin
    unique case (strb.width)
      W64:     nextRes = {{(DW-NARROW_W){1'b0}}, narrowAll[strb.elem]};
      W128:    nextRes = {upperKeep, wideAll[strb.elem][LANE_W-1:0]};
      W256:    nextRes = wideAll[strb.elem];
      default: nextRes = '0;
    endcase
    if (strb.err) nextRes = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)            resultQ <= '0;
    else if (strb.load) resultQ <= nextRes;
  end

  // R6: zeroing mode clears the upper destination half
  a_r6_zero_upper: assert property (@(posedge clk) disable iff (rst)
    $past(strb.load && strb.width == W128 && strb.zeroHi && !strb.err)
      |-> resultQ[DW-1:LANE_W] == '0);
  // R5: merging mode keeps the old destination upper half
  a_r5_merge_upper: assert property (@(posedge clk) disable iff (rst)
    $past(strb.load && strb.width == W128 && !strb.zeroHi && !strb.err)
      |-> resultQ[DW-1:LANE_W] == $past(oldDest[DW-1:LANE_W]));
  // R7: 64-bit results have nothing above the narrow group
  a_r7_narrow_upper: assert property (@(posedge clk) disable iff (rst)
    $past(strb.load && strb.width == W64)
      |-> resultQ[DW-1:NARROW_W] == '0);
endmodule

// File: rtl/simd_hi_interleave.sv
module simd_hi_interleave
  import hi_ilv_pkg::*;
#(
  parameter int DW       = 256,
  parameter int LANE_W   = 128,
  parameter int NARROW_W = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inValid,
  input  logic [1:0]    widthSel,
  input  logic [1:0]    elemSel,
  input  logic          zeroUpper,
  input  logic [DW-1:0] srcA,
  input  logic [DW-1:0] srcB,
  input  logic [DW-1:0] oldDest,
  output logic          outValid,
  output logic [DW-1:0] result,
  output logic          errOut
);
  ilvStrobe_t strb;

  hi_ilv_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .widthSel (widthSel),
    .elemSel  (elemSel),
    .zeroUpper(zeroUpper),
    .strb     (strb),
    .outValid (outValid),
    .errOut   (errOut)
  );

  hi_ilv_datapath #(.DW(DW), .LANE_W(LANE_W), .NARROW_W(NARROW_W)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strb   (strb),
    .srcA   (srcA),
    .srcB   (srcB),
    .oldDest(oldDest),
    .resultQ(result)
  );

  // R8: an illegal combination produces a zero result
  a_r8_err_zero_result: assert property (@(posedge clk) disable iff (rst)
    (outValid && errOut) |-> result == '0);
endmodule

// File: tb/simd_hi_interleave_tb.sv
module simd_hi_interleave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 256;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          inValid = 1'b0;
  logic [1:0]    widthSel = '0;
  logic [1:0]    elemSel = '0;
  logic          zeroUpper = 1'b0;
  logic [DW-1:0] srcA = '0, srcB = '0, oldDest = '0;
  logic          outValid, errOut;
  logic [DW-1:0] result;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string curTag = "R2";

  simd_hi_interleave dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .widthSel(widthSel),
    .elemSel(elemSel), .zeroUpper(zeroUpper), .srcA(srcA), .srcB(srcB),
    .oldDest(oldDest), .outValid(outValid), .result(result), .errOut(errOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit refIllegal(input logic [1:0] w, input logic [1:0] e);
    return (w == 2'd3) || (w == 2'd0 && e == 2'd3);
  endfunction

  // Behavioural reference, bit by bit
  function automatic logic [DW-1:0] refModel(input logic [1:0] w, input logic [1:0] e,
      input logic z, input logic [DW-1:0] a, input logic [DW-1:0] b, input logic [DW-1:0] d);
    logic [DW-1:0] r;
    int ew, grp, ngrp;
    r = '0;
    if (refIllegal(w, e)) return r;
    ew = 8 << e;
    grp = (w == 2'd0) ? 64 : 128;
    ngrp = (w == 2'd2) ? 2 : 1;
    for (int g = 0; g < ngrp; g++)
      for (int j = 0; j < grp/2/ew; j++)
        for (int t = 0; t < ew; t++) begin
          r[g*grp + 2*j*ew + t]      = a[g*grp + grp/2 + j*ew + t];
          r[g*grp + 2*j*ew + ew + t] = b[g*grp + grp/2 + j*ew + t];
        end
    if (w == 2'd1 && !z)
      for (int t = 128; t < 256; t++) r[t] = d[t];
    return r;
  endfunction

  logic          refValid = 1'b0, refErr = 1'b0;
  logic [DW-1:0] refRes = '0;
  string         refTag = "R2";

  always @(posedge clk) begin
    if (rst) begin
      refValid <= 1'b0;
      refErr   <= 1'b0;
    end else begin
      refValid <= inValid;
      refErr   <= inValid && refIllegal(widthSel, elemSel);
      if (inValid) begin
        refRes <= refModel(widthSel, elemSel, zeroUpper, srcA, srcB, oldDest);
        refTag <= curTag;
      end
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (outValid !== refValid) begin
        failures++;
        $display("FAIL R2 outValid act=%0b exp=%0b", outValid, refValid);
      end
      checks++;
      if (errOut !== refErr) begin
        failures++;
        $display("FAIL R8 errOut act=%0b exp=%0b", errOut, refErr);
      end
      if (refValid) begin
        checks++;
        if (result !== refRes) begin
          failures++;
          $display("FAIL %s result act=%h exp=%h", refTag, result, refRes);
        end
      end
    end
  end

  function automatic logic [DW-1:0] rnd256();
    logic [DW-1:0] v;
    for (int i = 0; i < DW/32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic string tagFor(input logic [1:0] w, input logic [1:0] e, input logic z);
    if (refIllegal(w, e)) return "R8";
    if (w == 2'd0) return "R7";
    if (w == 2'd2) return "R3";
    return z ? "R6" : "R5";
  endfunction

  // Apply one transaction and return the result seen one cycle later
  task automatic run1(input logic [1:0] w, input logic [1:0] e, input logic z,
      input logic [DW-1:0] a, input logic [DW-1:0] b, input logic [DW-1:0] d,
      input string tag, output logic [DW-1:0] res);
    @(posedge clk); #1;
    widthSel = w; elemSel = e; zeroUpper = z;
    srcA = a; srcB = b; oldDest = d; inValid = 1'b1; curTag = tag;
    @(posedge clk); #1;
    inValid = 1'b0;
    @(negedge clk);
    res = result;
  endtask

  task automatic checkVec(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] r1, r2, a, b, exp;
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || errOut !== 1'b0) begin
      failures++;
      $display("FAIL R1 act=%0b%0b exp=00", outValid, errOut);
    end
    @(posedge clk); #1; rst = 1'b0;
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || errOut !== 1'b0) begin
      failures++;
      $display("FAIL R1 after release act=%0b%0b exp=00", outValid, errOut);
    end

    // R10 / R3: 16-bit elements, 256-bit, counting pattern
    for (int i = 0; i < 16; i++) begin
      a[i*16 +: 16] = 16'hA000 + 16'(i);
      b[i*16 +: 16] = 16'hB000 + 16'(i);
    end
    exp = '0;
    for (int l = 0; l < 2; l++)
      for (int j = 0; j < 4; j++) begin
        exp[l*128 + 2*j*16 +: 16]      = 16'hA000 + 16'(l*8 + 4 + j);
        exp[l*128 + (2*j+1)*16 +: 16]  = 16'hB000 + 16'(l*8 + 4 + j);
      end
    run1(2'd2, 2'd1, 1'b0, a, b, '0, "R10", r1);
    checkVec("R10 16-bit element order", r1, exp);

    // R9: zero second source gives zero-extended bytes
    a = rnd256();
    run1(2'd2, 2'd0, 1'b0, a, '0, '0, "R9", r1);
    exp = '0;
    for (int l = 0; l < 2; l++)
      for (int j = 0; j < 8; j++)
        exp[l*128 + j*16 +: 16] = {8'h00, a[l*128 + 64 + j*8 +: 8]};
    checkVec("R9 zero extension", r1, exp);

    // R4: lower halves ignored
    a = rnd256(); b = rnd256();
    run1(2'd2, 2'd2, 1'b0, a, b, '0, "R4", r1);
    a[63:0] = ~a[63:0]; a[191:128] = ~a[191:128];
    b[63:0] = ~b[63:0]; b[191:128] = ~b[191:128];
    run1(2'd2, 2'd2, 1'b0, a, b, '0, "R4", r2);
    checkVec("R4 lower halves ignored", r2, r1);

    // R7 / R8 / R5 / R6 directed
    run1(2'd0, 2'd3, 1'b0, rnd256(), rnd256(), rnd256(), "R8", r1);
    checkVec("R8 illegal 64/64 zero", r1, '0);
    run1(2'd3, 2'd0, 1'b0, rnd256(), rnd256(), rnd256(), "R8", r1);
    checkVec("R8 bad width zero", r1, '0);
    a = rnd256(); b = rnd256();
    run1(2'd0, 2'd2, 1'b0, a, b, rnd256(), "R7", r1);
    checkVec("R7 narrow dword", r1, {192'h0, b[63:32], a[63:32]});
    exp = rnd256();
    run1(2'd1, 2'd3, 1'b0, a, b, exp, "R5", r1);
    checkVec("R5 merge qword", r1, {exp[255:128], b[127:64], a[127:64]});
    run1(2'd1, 2'd3, 1'b1, a, b, exp, "R6", r1);
    checkVec("R6 zero qword", r1, {128'h0, b[127:64], a[127:64]});

    // R2 back-to-back random traffic against the model, all codes
    for (int n = 0; n < 400; n++) begin
      @(posedge clk); #1;
      widthSel = 2'($urandom); elemSel = 2'($urandom); zeroUpper = 1'($urandom);
      srcA = rnd256(); srcB = ($urandom % 5 == 0) ? '0 : rnd256(); oldDest = rnd256();
      inValid = ($urandom % 4) != 0;
      curTag = tagFor(widthSel, elemSel, zeroUpper);
    end
    @(posedge clk); #1; inValid = 1'b0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule